// File: doc/BRIEF.md
# Four-State Token Countdown Chain

This block is a countdown counter made of a chain of identical cells instead of a binary register with a borrow chain. Each cell holds one of four token states: Zero, One, Two or Done. The most significant cell sits at the left end and the least significant at the right end. Adjacent cells trade tokens by a local rule: whenever a non-Zero cell has a Zero cell to its right, the pair fires, and every eligible pair fires in the same clock cycle. A fixed cap at the left end behaves like a neighbour that is Done forever, so Done tokens flow rightward once the count is used up.

A consumer at the right end asks for decrements through a valid/ready handshake. An accepted request empties the least significant cell. One cycle later a single-cycle response reports success if that cell held One or Two and failure if it held Done. While the least significant cell is Zero (a refill is still in flight), ready stays low and the request waits. A synchronous parallel load writes every cell at once. A clear sets every cell to Done. Both take priority over firing and decrements.

Top module: `token_countdown`

## Requirements
- R1: Cell i occupies bits [2i+1:2i] of `state_out` and `load_vec`, with cell 0 the least significant (rightmost). The upper bit is high for Done or Two and the lower bit is high for One or Two, so Zero=2'b00, One=2'b01, Two=2'b11, Done=2'b10.
- R2: Synchronous active-high `rst` puts every cell in Done and holds `rsp_valid` low.
- R3: A pair of adjacent cells fires only when the left cell is non-Zero and the right cell is Zero. A cell in no firing pair and not drained keeps its state.
- R4: A firing pair with Two on the left becomes One on the left and Two on the right on the next clock.
- R5: A firing pair with One on the left becomes Zero on the left and Two on the right on the next clock.
- R6: A firing pair with Done on the left becomes Done on both sides on the next clock.
- R7: The leftmost cell has a permanent Done neighbour, so a Zero leftmost cell becomes Done on the next clock.
- R8: All eligible pairs fire in the same clock cycle.
- R9: `dec_ready` is high exactly when the least significant cell is non-Zero and neither `load_en` nor `clear_en` is high. A request accepted with `dec_valid` and `dec_ready` leaves that cell Zero on the next clock.
- R10: One clock after each acceptance, `rsp_valid` is high for exactly one cycle. `rsp_ok` is 1 if the drained cell was One or Two and 0 if it was Done.
- R11: `load_en` writes `load_vec` into all cells on the next clock, overriding firing and decrements.
- R12: `clear_en` sets every cell to Done on the next clock, overriding `load_en`, firing and decrements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_en | input | 1 | Set all cells to Done |
| load_en | input | 1 | Parallel load of all cells |
| load_vec | input | 2*NCELL | Per-cell load states |
| dec_valid | input | 1 | Decrement request |
| dec_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ok | output | 1 | Response result: 1 success, 0 exhausted |
| state_out | output | 2*NCELL | Registered state of every cell |

## Verification
Single-pair loads place Two, One or Done to the left of one Zero, so each of the three firing rules shows up on its own. An alternating Two/Zero load tells simultaneous firing apart from firing one pair per cycle. A Zero in only the leftmost cell exercises the cap. Long request streams from the cleared state, with the valid signal toggled pseudo-randomly and occasional loads and clears on top, are compared every cycle against a behavioural model. These streams expose errors in refill ordering, in the success/failure sequence, in the stalls while the least significant cell is Zero, and in the priority of load and clear over requests.

// File: rtl/tokchain_pkg.sv
package tokchain_pkg;
  // {done_or_two, one_or_two}
  typedef enum logic [1:0] {
    TK_ZERO = 2'b00,
    TK_ONE  = 2'b01,
    TK_DONE = 2'b10,
    TK_TWO  = 2'b11
  } tok_t;

  localparam int TOK_W = 2;
endpackage

// File: rtl/tokchain_cell.sv
module tokchain_cell
  import tokchain_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear_en,
  input  logic load_en,
  input  tok_t load_val,
  input  tok_t left_st,
  input  logic right_zero,
  input  logic drain,
  output tok_t st
);
  tok_t nxt;

  always_comb begin
    nxt = st;
    if (st == TK_ZERO && left_st != TK_ZERO) begin
      // right member of a firing pair
      nxt = (left_st == TK_DONE) ? TK_DONE : TK_TWO;
    end else if (drain) begin
      nxt = TK_ZERO;
    end else if (right_zero) begin
      // left member of a firing pair
      case (st)
        TK_TWO:  nxt = TK_ONE;
        TK_ONE:  nxt = TK_ZERO;
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_en) st <= TK_DONE;
    else if (load_en)    st <= load_val;
    else                 st <= nxt;
  end

  // R6: Done only leaves through a drain, load or clear
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (st == TK_DONE && !load_en && !drain) |=> (st == TK_DONE));

  // R3: a Zero cell with a Zero left neighbour does not change
  a_r3_zero_holds: assert property (@(posedge clk) disable iff (rst)
    (st == TK_ZERO && left_st == TK_ZERO && !load_en && !clear_en) |=> (st == TK_ZERO));

  // R12: clear wins over everything
  a_r12_clear_done: assert property (@(posedge clk) disable iff (rst)
    clear_en |=> (st == TK_DONE));
endmodule

// File: rtl/tokchain_drain.sv
module tokchain_drain
  import tokchain_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear_en,
  input  logic load_en,
  input  logic dec_valid,
  input  tok_t lsb_st,
  output logic dec_ready,
  output logic drain_go,
  output logic rsp_valid,
  output logic rsp_ok
);
  assign dec_ready = !load_en && !clear_en && (lsb_st != TK_ZERO);
  assign drain_go  = dec_valid && dec_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= drain_go;
      rsp_ok    <= drain_go && (lsb_st != TK_DONE);
    end
  end

  // R10: response is a single-cycle pulse
  a_r10_pulse_once: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9: an accepted request empties the LSB cell
  a_r9_drain_empties: assert property (@(posedge clk) disable iff (rst)
    drain_go |=> (lsb_st == TK_ZERO));

  // R10: result reflects the drained state
  a_r10_ok_matches: assert property (@(posedge clk) disable iff (rst)
    drain_go |=> (rsp_valid && rsp_ok == ($past(lsb_st) != TK_DONE)));
endmodule

// File: rtl/token_countdown.sv
module token_countdown
  import tokchain_pkg::*;
#(
  parameter int NCELL = 8,
  localparam int VW = NCELL * TOK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_en,
  input  logic          load_en,
  input  logic [VW-1:0] load_vec,
  input  logic          dec_valid,
  output logic          dec_ready,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [VW-1:0] state_out
);
  tok_t cst [NCELL];
  logic drain_go;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    tok_t left_n;
    logic rz;
    logic dr;

    if (i == NCELL - 1) begin : g_cap
      assign left_n = TK_DONE;
    end else begin : g_mid
      assign left_n = cst[i+1];
    end

    if (i == 0) begin : g_lsb
      assign rz = 1'b0;
      assign dr = drain_go;
    end else begin : g_up
      assign rz = (cst[i-1] == TK_ZERO);
      assign dr = 1'b0;
    end

    tokchain_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .clear_en   (clear_en),
      .load_en    (load_en),
      .load_val   (tok_t'(load_vec[TOK_W*i +: TOK_W])),
      .left_st    (left_n),
      .right_zero (rz),
      .drain      (dr),
      .st         (cst[i])
    );

    assign state_out[TOK_W*i +: TOK_W] = cst[i];
  end

  tokchain_drain u_drain (
    .clk       (clk),
    .rst       (rst),
    .clear_en  (clear_en),
    .load_en   (load_en),
    .dec_valid (dec_valid),
    .lsb_st    (cst[0]),
    .dec_ready (dec_ready),
    .drain_go  (drain_go),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok)
  );

  // R7: the cap refills an empty MSB with Done
  a_r7_cap_refill: assert property (@(posedge clk) disable iff (rst)
    (cst[NCELL-1] == TK_ZERO && !load_en && !clear_en) |=> (cst[NCELL-1] == TK_DONE));

  // R11: load lands on the next clock
  a_r11_load_lands: assert property (@(posedge clk) disable iff (rst)
    (load_en && !clear_en) |=> (state_out == $past(load_vec)));
endmodule

// File: tb/token_countdown_test.sv
module token_countdown_test;
  localparam int N  = 8;
  localparam int VW = 2 * N;
  localparam int Z = 0, O = 1, D = 2, T = 3;

  logic clk = 1'b0;
  logic rst, clear_en, load_en, dec_valid;
  logic [VW-1:0] load_vec;
  logic dec_ready, rsp_valid, rsp_ok;
  logic [VW-1:0] state_out;

  int total = 0;
  int fails = 0;
  int m [N];
  logic exp_rv, exp_ok;

  always #4 clk = ~clk;

  token_countdown #(.NCELL(N)) uut (
    .clk(clk), .rst(rst), .clear_en(clear_en), .load_en(load_en),
    .load_vec(load_vec), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .state_out(state_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] packm();
    logic [VW-1:0] v = '0;
    for (int i = 0; i < N; i++) v[2*i +: 2] = m[i][1:0];
    return v;
  endfunction

  function automatic logic [VW-1:0] packa(input int a [N]);
    logic [VW-1:0] v = '0;
    for (int i = 0; i < N; i++) v[2*i +: 2] = a[i][1:0];
    return v;
  endfunction

  // behavioural reference: walk pairs over a snapshot
  task automatic model_step(input bit acc, input bit ld, input bit cl, input logic [VW-1:0] lv);
    int o [N];
    int n [N];
    o = m;
    n = m;
    if (cl) begin
      for (int i = 0; i < N; i++) n[i] = D;
    end else if (ld) begin
      for (int i = 0; i < N; i++) n[i] = int'(lv[2*i +: 2]);
    end else begin
      for (int p = N - 1; p >= 0; p--) begin
        int l;
        l = (p == N - 1) ? D : o[p+1];
        if (l != Z && o[p] == Z) begin
          if (l == D) n[p] = D;
          else begin
            n[p] = T;
            if (p < N - 1) n[p+1] = (l == T) ? O : Z;
          end
        end
      end
      if (acc) n[0] = Z;
    end
    m = n;
  endtask

  task automatic tick(input bit dv, input bit ld, input bit cl, input logic [VW-1:0] lv);
    bit er, acc;
    @(negedge clk);
    dec_valid = dv; load_en = ld; clear_en = cl; load_vec = lv;
    #1;
    er = !ld && !cl && (m[0] != Z);
    chk("R9 dec_ready", dec_ready, er);
    acc = dv && er;
    exp_rv = acc;
    exp_ok = acc && (m[0] != D);
    model_step(acc, ld, cl, lv);
    @(posedge clk);
    #2;
    chk("R8 state vs model", state_out, packm());
    chk("R10 rsp_valid", rsp_valid, exp_rv);
    if (exp_rv) chk("R10 rsp_ok", rsp_ok, exp_ok);
  endtask

  task automatic load_then_fire(input int a [N], input int e [N], input string tag);
    tick(0, 1, 0, packa(a));
    chk({tag, " load"}, state_out, packa(a));
    tick(0, 0, 0, '0);
    chk(tag, state_out, packa(e));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int a [N];
    int e [N];
    logic [15:0] lf;
    rst = 1'b1; clear_en = 0; load_en = 0; dec_valid = 0; load_vec = '0;
    exp_rv = 0; exp_ok = 0;
    for (int i = 0; i < N; i++) m[i] = D;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R2 / R1: Done is 2'b10 in every cell
    chk("R2 reset state", state_out, {N{2'b10}});
    chk("R2 reset rsp", rsp_valid, 1'b0);

    // R4: Two left of Zero
    for (int i = 0; i < N; i++) a[i] = T;
    a[0] = Z;
    e = a; e[1] = O; e[0] = T;
    load_then_fire(a, e, "R4 two rule");
    // R5: One left of Zero
    a[1] = O; e = a; e[1] = Z; e[0] = T;
    load_then_fire(a, e, "R5 one rule");
    // R6: Done left of Zero
    a[1] = D; e = a; e[0] = D;
    load_then_fire(a, e, "R6 done rule");
    // R7: empty MSB refilled by the cap
    for (int i = 0; i < N; i++) a[i] = D;
    a[N-1] = Z; e = a; e[N-1] = D;
    load_then_fire(a, e, "R7 cap");
    // R8: every other pair fires together
    for (int i = 0; i < N; i++) begin
      a[i] = (i % 2 == 1) ? T : Z;
      e[i] = (i % 2 == 1) ? O : T;
    end
    load_then_fire(a, e, "R8 parallel");
    // R3: no Zero anywhere -> nothing moves
    for (int i = 0; i < N; i++) a[i] = (i % 2 == 0) ? O : T;
    load_then_fire(a, a, "R3 stable");

    // R11: load beats a pending request
    for (int i = 0; i < N; i++) a[i] = O;
    tick(1, 1, 0, packa(a));
    chk("R11 load priority", state_out, packa(a));
    chk("R11 no response", rsp_valid, 1'b0);
    // R12: clear beats load
    for (int i = 0; i < N; i++) a[i] = Z;
    tick(1, 1, 1, packa(a));
    chk("R12 clear priority", state_out, {N{2'b10}});

    // R9 / R10: run down from a small load
    for (int i = 0; i < N; i++) a[i] = Z;
    a[0] = O;
    tick(0, 1, 0, packa(a));
    tick(1, 0, 0, '0);
    chk("R10 success on One", {rsp_valid, rsp_ok}, 2'b11);
    chk("R9 lsb drained", state_out[1:0], 2'b00);
    repeat (40) tick(1, 0, 0, '0);

    // long mixed stream
    lf = 16'hACE1;
    for (int k = 0; k < 1500; k++) begin
      bit cl, ld, dv;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      dv = lf[0] | lf[3];
      cl = (lf[9:4] == 6'd0);
      ld = (lf[9:4] == 6'd1);
      tick(dv, ld, cl, {lf[7:0], lf[15:8]});
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule